// File: doc/BRIEF.md
# Job-Slot Interrupt Controller

This block gathers completion and failure events from sixteen job slots into a single interrupt line. Every slot has two sticky bits in a 32-bit raw event word: a completion bit in the lower half and a failure bit in the upper half. Software removes events by writing ones to a clear register. An enable register decides which raw bits show up in the masked status and so drive the interrupt output.

Alongside the events, the block keeps a job-state word. Each slot has a bit that shows a running job and a bit that shows a queued follow-on job. The slots present their live running and queued flags at all times. The block copies them into the job-state word only when the clear register is written, and only for the slots that the written value names. Software can therefore acknowledge a slot's events and take a consistent view of that slot's progress in one write.

A word-addressed register port reaches the controller's own registers below a slot window. Any access at or above the window base goes out on a per-slot port as a slot number and an offset within the slot. Read data comes back one cycle after the request, whichever target answers.

Top module: `jobslot_irq_ctrl`

## Requirements
- R1: A pulse on `done_evt[N]` sets raw bit N, and a pulse on `fail_evt[N]` sets raw bit 16+N. A set bit stays set until software clears it.
- R2: A write to the clear register (byte offset 0x04) clears every raw bit whose written bit is 1. Raw bits written as 0 keep their value.
- R3: When an event and a clear of the same raw bit fall in one cycle, the event wins and the bit reads back as 1.
- R4: The masked status (offset 0x0C) reads as raw AND enable (offset 0x08). `irq` is high exactly when at least one masked status bit is 1.
- R5: After reset the raw word, the enable word, the job-state word, `bus_rdata` and `irq` are all zero.
- R6: Writes to the raw register (offset 0x00) and to the masked status register (offset 0x0C) change nothing.
- R7: A clear write selects slot N when written bit N or written bit 16+N is 1. For each selected slot, job-state (offset 0x10) bit N is loaded from `slot_active[N]` and bit 16+N from `slot_queued[N]`, using the values present in the write cycle.
- R8: Job-state bits of slots that a clear write does not select keep their previous values. Nothing other than a clear write changes the job-state word.
- R9: An access with address at or above 0x800 appears on the slot port in the same cycle. `sp_slot` is (addr-0x800)/128 and `sp_off` is the low 7 bits of addr-0x800. Such an access leaves the controller's own registers untouched. Addresses below 0x800 never raise `sp_valid`.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. A forwarded read returns the `sp_rdata` value present in the request cycle.
- R11: Reads of the clear register and of unmapped offsets below 0x800 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| done_evt | input | 16 | Per-slot completion event pulses |
| fail_evt | input | 16 | Per-slot failure event pulses |
| slot_active | input | 16 | Per-slot running-job flag |
| slot_queued | input | 16 | Per-slot queued-next-job flag |
| irq | output | 1 | Interrupt request |
| sp_valid | output | 1 | Forwarded slot access |
| sp_we | output | 1 | Forwarded access is a write |
| sp_slot | output | 4 | Target slot index |
| sp_off | output | 7 | Byte offset within the slot |
| sp_wdata | output | 32 | Forwarded write data |
| sp_rdata | input | 32 | Slot read data, sampled in the request cycle |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that let the clear win would lose the event and read back zero. It also writes clear values that name slots through the upper half only, then through neither half. This catches a refresh that ignores the failure half, or one that touches slots the write never named, because that would wipe a running bit that should stay. Accesses at 0x7FC, 0x800 and 0xFFC probe both edges of the slot window: a comparison off by one would forward an own-register access or miss slot 15. Reads issued back to back show whether a late read path returns the previous value.

// File: rtl/jsi_pkg.sv
package jsi_pkg;

   // Word index of the controller's own registers (byte address bits [4:2]).
   typedef enum logic [2:0] {
      OWN_RAW   = 3'd0,
      OWN_CLR   = 3'd1,
      OWN_ENA   = 3'd2,
      OWN_STAT  = 3'd3,
      OWN_STATE = 3'd4
   } own_reg_e;

   localparam int OWN_IDX_LSB = 2;
   localparam int OWN_IDX_W   = 3;
   localparam int OWN_SPAN_W  = OWN_IDX_LSB + OWN_IDX_W;

endpackage

// File: rtl/jsi_addr_decode.sv
module jsi_addr_decode
   import jsi_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int SLOT_BASE  = 'h800,
   parameter int SLOT_OFF_W = 7,
   parameter int SLOT_IDX_W = 4
) (
   input  logic                  sel,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  own_hit,
   output logic                  own_known,
   output own_reg_e              own_reg,
   output logic                  fwd_hit,
   output logic [SLOT_IDX_W-1:0] fwd_slot,
   output logic [SLOT_OFF_W-1:0] fwd_off
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SLOT_BASE);
   localparam int                WIN_W  = SLOT_OFF_W + SLOT_IDX_W;

   logic [ADDR_W-1:0] rel;
   logic              above_base;
   logic              in_window;
   logic [OWN_IDX_W-1:0] idx;
   logic              upper_zero;

   if (WIN_W > ADDR_W) begin : g_bad_window
      $error("slot window wider than the address");
   end
   if (OWN_SPAN_W >= ADDR_W) begin : g_bad_own
      $error("own register span does not fit below the address width");
   end

   assign rel        = addr - BASE_A;
   assign above_base = (addr >= BASE_A);

   if (ADDR_W > WIN_W) begin : g_window_check
      assign in_window = ~|rel[ADDR_W-1:WIN_W];
   end else begin : g_window_full
      assign in_window = 1'b1;
   end

   assign fwd_hit  = sel && above_base && in_window;
   assign fwd_slot = rel[SLOT_OFF_W +: SLOT_IDX_W];
   assign fwd_off  = rel[SLOT_OFF_W-1:0];

   assign idx        = addr[OWN_IDX_LSB +: OWN_IDX_W];
   assign upper_zero = ~|addr[ADDR_W-1:OWN_SPAN_W];
   assign own_hit    = sel && !above_base;
   assign own_reg    = own_reg_e'(idx);
   assign own_known  = own_hit && upper_zero && (addr[OWN_IDX_LSB-1:0] == '0) &&
                       (idx <= OWN_IDX_W'(OWN_STATE));

endmodule

// File: rtl/jsi_irq_regs.sv
module jsi_irq_regs #(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] done_evt,
   input  logic [NUM_SLOTS-1:0] fail_evt,
   input  logic                 clr_wr,
   input  logic                 ena_wr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    raw_q,
   output logic [DATA_W-1:0]    ena_q
);

   localparam int HALF = DATA_W / 2;

   if (NUM_SLOTS > HALF) begin : g_bad_slots
      $error("event word cannot hold two bits per slot");
   end

   logic [DATA_W-1:0] evt_vec;
   logic [DATA_W-1:0] clr_vec;

   // Completion events sit in the lower half, failures in the upper half.
   for (genvar b = 0; b < DATA_W; b++) begin : g_evt
      if (b < NUM_SLOTS) begin : g_done
         assign evt_vec[b] = done_evt[b];
      end else if (b >= HALF && b < HALF + NUM_SLOTS) begin : g_fail
         assign evt_vec[b] = fail_evt[b-HALF];
      end else begin : g_none
         assign evt_vec[b] = 1'b0;
      end
   end

   assign clr_vec = clr_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_vec) | evt_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
      end else if (ena_wr) begin
         ena_q <= wdata;
      end
   end

   // R3: an event survives a clear in the same cycle
   a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_vec) |=> ((raw_q & $past(evt_vec)) == $past(evt_vec)));

   // R2: cleared bits without a coincident event drop
   a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((raw_q & $past(wdata & ~evt_vec)) == '0));

   // R1: without a clear, set bits stay set
   a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

   // R6: raw changes only through events or clears
   a_r6_raw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && evt_vec == '0) |=> $stable(raw_q));

endmodule

// File: rtl/jsi_state_track.sv
module jsi_state_track #(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_wr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_SLOTS-1:0] slot_active,
   input  logic [NUM_SLOTS-1:0] slot_queued,
   output logic [DATA_W-1:0]    state_q
);

   localparam int HALF = DATA_W / 2;

   logic [NUM_SLOTS-1:0] pick;
   logic [NUM_SLOTS-1:0] run_q;
   logic [NUM_SLOTS-1:0] nxt_q;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign pick[s] = clr_wr && (wdata[s] || wdata[HALF+s]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q[s] <= 1'b0;
            nxt_q[s] <= 1'b0;
         end else if (pick[s]) begin
            run_q[s] <= slot_active[s];
            nxt_q[s] <= slot_queued[s];
         end
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_pack
      if (b < NUM_SLOTS) begin : g_run
         assign state_q[b] = run_q[b];
      end else if (b >= HALF && b < HALF + NUM_SLOTS) begin : g_nxt
         assign state_q[b] = nxt_q[b-HALF];
      end else begin : g_zero
         assign state_q[b] = 1'b0;
      end
   end

   // R8: only a clear write can move the job-state word
   a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> $stable(state_q));

   // R8: unselected slots keep their bits across a clear write
   a_r8_unpicked_keep: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (((run_q ^ $past(run_q)) & ~$past(pick)) == '0));

   // R7: selected slots follow the live flags of the write cycle
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((run_q & $past(pick)) == ($past(slot_active) & $past(pick))));

endmodule

// File: rtl/jobslot_irq_ctrl.sv
module jobslot_irq_ctrl
   import jsi_pkg::*;
#(
   parameter int NUM_SLOTS  = 16,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 12,
   parameter int SLOT_BASE  = 'h800,
   parameter int SLOT_OFF_W = 7,
   parameter int SLOT_IDX_W = $clog2(NUM_SLOTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [NUM_SLOTS-1:0]  done_evt,
   input  logic [NUM_SLOTS-1:0]  fail_evt,
   input  logic [NUM_SLOTS-1:0]  slot_active,
   input  logic [NUM_SLOTS-1:0]  slot_queued,
   output logic                  irq,
   output logic                  sp_valid,
   output logic                  sp_we,
   output logic [SLOT_IDX_W-1:0] sp_slot,
   output logic [SLOT_OFF_W-1:0] sp_off,
   output logic [DATA_W-1:0]     sp_wdata,
   input  logic [DATA_W-1:0]     sp_rdata
);

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("data width must be even");
   end
   if ((1 << SLOT_IDX_W) < NUM_SLOTS) begin : g_bad_idx
      $error("slot index too narrow");
   end

   logic        own_hit;
   logic        own_known;
   own_reg_e    own_reg;
   logic        fwd_hit;
   logic        clr_wr;
   logic        ena_wr;
   logic        rd_req;
   logic [DATA_W-1:0] raw_q;
   logic [DATA_W-1:0] ena_q;
   logic [DATA_W-1:0] stat;
   logic [DATA_W-1:0] state_q;
   logic [DATA_W-1:0] own_rdata;

   jsi_addr_decode #(
      .ADDR_W    (ADDR_W),
      .SLOT_BASE (SLOT_BASE),
      .SLOT_OFF_W(SLOT_OFF_W),
      .SLOT_IDX_W(SLOT_IDX_W)
   ) u_dec (
      .sel      (bus_sel),
      .addr     (bus_addr),
      .own_hit  (own_hit),
      .own_known(own_known),
      .own_reg  (own_reg),
      .fwd_hit  (fwd_hit),
      .fwd_slot (sp_slot),
      .fwd_off  (sp_off)
   );

   assign clr_wr = own_known && bus_we && (own_reg == OWN_CLR);
   assign ena_wr = own_known && bus_we && (own_reg == OWN_ENA);
   assign rd_req = bus_sel && !bus_we;

   jsi_irq_regs #(
      .NUM_SLOTS(NUM_SLOTS),
      .DATA_W   (DATA_W)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_evt(done_evt),
      .fail_evt(fail_evt),
      .clr_wr  (clr_wr),
      .ena_wr  (ena_wr),
      .wdata   (bus_wdata),
      .raw_q   (raw_q),
      .ena_q   (ena_q)
   );

   jsi_state_track #(
      .NUM_SLOTS(NUM_SLOTS),
      .DATA_W   (DATA_W)
   ) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_wr     (clr_wr),
      .wdata      (bus_wdata),
      .slot_active(slot_active),
      .slot_queued(slot_queued),
      .state_q    (state_q)
   );

   assign stat = raw_q & ena_q;
   assign irq  = |stat;

   assign sp_valid = fwd_hit;
   assign sp_we    = fwd_hit && bus_we;
   assign sp_wdata = bus_wdata;

   always_comb begin
      own_rdata = '0;
      if (own_known) begin
         unique case (own_reg)
            OWN_RAW:   own_rdata = raw_q;
            OWN_ENA:   own_rdata = ena_q;
            OWN_STAT:  own_rdata = stat;
            OWN_STATE: own_rdata = state_q;
            default:   own_rdata = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (rd_req) begin
         bus_rdata <= fwd_hit ? sp_rdata : own_rdata;
      end
   end

   // R9: an access goes to exactly one target
   a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_hit, own_hit}));

   // R4: the interrupt needs at least one enabled bit
   a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ena_q != '0));

   // R10: read data holds between reads
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(bus_rdata));

   // R10: a forwarded read returns the slot data of the request cycle
   a_r10_fwd_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && fwd_hit) |=> (bus_rdata == $past(sp_rdata)));

endmodule

// File: tb/jobslot_irq_ctrl_tb.sv
`timescale 1ns/1ps
module jobslot_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] done_evt = '0;
   logic [15:0] fail_evt = '0;
   logic [15:0] slot_active = '0;
   logic [15:0] slot_queued = '0;
   logic        irq;
   logic        sp_valid;
   logic        sp_we;
   logic [3:0]  sp_slot;
   logic [6:0]  sp_off;
   logic [31:0] sp_wdata;
   logic [31:0] sp_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_fired = 1'b0;

   always #2.5 clk = ~clk;

   // Slot-side model: read data encodes the slot and offset it was asked for.
   assign sp_rdata = {16'hC0DE, 4'h0, sp_slot, 1'b0, sp_off};

   jobslot_irq_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .done_evt   (done_evt),
      .fail_evt   (fail_evt),
      .slot_active(slot_active),
      .slot_queued(slot_queued),
      .irq        (irq),
      .sp_valid   (sp_valid),
      .sp_we      (sp_we),
      .sp_slot    (sp_slot),
      .sp_off     (sp_off),
      .sp_wdata   (sp_wdata),
      .sp_rdata   (sp_rdata)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: a read issued at one edge has its data ready by the next falling edge.
   always @(posedge clk) rd_fired <= rst_n && bus_sel && !bus_we;

   always @(negedge clk) begin
      if (rd_fired) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected read result", bus_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, bus_rdata, e);
         end
      end
   end

   // Driver tasks: entered at a falling edge, leave at the next falling edge.
   task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, logic [15:0] dn = '0, logic [15:0] fl = '0);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      done_evt = dn; fail_evt = fl;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; done_evt = '0; fail_evt = '0;
   endtask

   task automatic pulse(logic [15:0] dn, logic [15:0] fl);
      done_evt = dn; fail_evt = fl;
      @(negedge clk);
      done_evt = '0; fail_evt = '0;
   endtask

   task automatic probe(logic we, logic [11:0] a, logic exp_v, logic [3:0] exp_s,
                        logic [6:0] exp_o, string tag);
      bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = 32'hFFFF_FFFF;
      if (!we) begin
         if (exp_v) begin
            exp_q.push_back({16'hC0DE, 4'h0, exp_s, 1'b0, exp_o});
         end else begin
            exp_q.push_back(32'h0);
         end
         tag_q.push_back({tag, " data"});
      end
      #1;
      chk({tag, " valid"}, {31'h0, sp_valid}, {31'h0, exp_v});
      if (exp_v) begin
         chk({tag, " slot/off/we"}, {20'h0, sp_we, sp_slot, sp_off}, {20'h0, we, exp_s, exp_o});
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R5: reset state
      chk("R5 rdata after reset", bus_rdata, 32'h0);
      chk("R5 irq after reset", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h000, 32'h0, "R5 raw after reset");
      rd(12'h008, 32'h0, "R5 enable after reset");
      rd(12'h010, 32'h0, "R5 job-state after reset");

      // R1: completion to bit N, failure to bit 16+N
      pulse(16'h0001, 16'h0004);
      rd(12'h000, 32'h0004_0001, "R1 raw after events");
      chk("R4 irq masked off", {31'h0, irq}, 32'h0);

      // R4: enable bit 0
      wr(12'h008, 32'h0000_0001);
      chk("R4 irq with enable", {31'h0, irq}, 32'h1);
      rd(12'h00C, 32'h0000_0001, "R4 masked status");

      // R6: writes to raw and status are ignored
      wr(12'h000, 32'hFFFF_FFFF);
      wr(12'h00C, 32'h0000_0000);
      rd(12'h000, 32'h0004_0001, "R6 raw unchanged");
      rd(12'h00C, 32'h0000_0001, "R6 status unchanged");

      // R2/R7/R8: clear slot 0 completion, refresh slot 0 only
      slot_active = 16'h0003; slot_queued = 16'h0001;
      wr(12'h004, 32'h0000_0001);
      chk("R2 irq drops after clear", {31'h0, irq}, 32'h0);
      rd(12'h000, 32'h0004_0000, "R2 raw after clear");
      rd(12'h010, 32'h0001_0001, "R7 job-state slot0 reload, R8 slot1 untouched");

      // R3: event and clear of the same bit together
      wr(12'h004, 32'h0000_0020, 16'h0020, 16'h0000);
      rd(12'h000, 32'h0004_0020, "R3 event beats clear");
      rd(12'h010, 32'h0001_0001, "R7 slot5 reloaded to zero");

      // R7/R8: selection through the upper half only
      slot_active = 16'h0004; slot_queued = 16'h0004;
      wr(12'h004, 32'h0004_0000);
      rd(12'h000, 32'h0000_0020, "R2 failure bit cleared");
      rd(12'h010, 32'h0005_0005, "R8 slot0 kept, R7 slot2 loaded");

      // R2: a zero clear leaves everything
      wr(12'h004, 32'h0000_0000);
      rd(12'h000, 32'h0000_0020, "R2 zero clear keeps raw");
      rd(12'h010, 32'h0005_0005, "R8 zero clear keeps job-state");
      wr(12'h008, 32'h0000_0020);
      chk("R4 irq from completion bit 5", {31'h0, irq}, 32'h1);

      // R9: forwarding and window edges
      probe(1'b0, 12'h994, 1'b1, 4'd3, 7'h14, "R9 slot3 read");
      probe(1'b1, 12'h808, 1'b1, 4'd0, 7'h08, "R9 slot0 write");
      rd(12'h008, 32'h0000_0020, "R9 forwarded write leaves enable");
      rd(12'h000, 32'h0000_0020, "R9 forwarded write leaves raw");
      probe(1'b0, 12'h7FC, 1'b0, 4'd0, 7'h00, "R9 R11 below window");
      probe(1'b0, 12'h800, 1'b1, 4'd0, 7'h00, "R9 window base");
      probe(1'b0, 12'hFFC, 1'b1, 4'd15, 7'h7C, "R9 last slot");

      // R11: clear register and unmapped offsets read zero
      rd(12'h004, 32'h0, "R11 clear reads zero");
      rd(12'h014, 32'h0, "R11 unmapped offset");

      // R10: back-to-back reads to different targets
      rd(12'h000, 32'h0000_0020, "R10 b2b raw");
      rd(12'h010, 32'h0005_0005, "R10 b2b job-state");
      rd(12'h8A0, 32'hC0DE_0120, "R10 b2b slot1 read");
      rd(12'h008, 32'h0000_0020, "R10 b2b enable");
      chk("R10 rdata holds (last result)", bus_rdata, 32'h0000_0020);

      repeat (3) @(negedge clk);
      chk("R10 all reads answered", exp_q.size(), 32'h0);
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #50000;
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule